// File: doc/BRIEF.md
# Indexed Host Register and Colour Table Port

This block is the host-side access port of a video encoder. A byte-wide, clock-synchronous host bus with a select, a read/write flag and a two-bit function code reaches two things. One is a small file of byte-wide control registers. The other is a 256-entry colour table of 24-bit entries. The host first loads a pointer and then streams data bytes. Each data access moves the pointer on by itself, so a burst of accesses covers consecutive locations.

The colour table is loaded the way a graphics palette is loaded: three byte writes per entry, in the order red, green, blue. The entry is committed as one 24-bit word when the blue byte arrives, and the index then advances. Reads follow the same three-byte order. The video pipeline reads the table through a separate registered lookup port.

The block also owns encoder start-up. The reset pin stops the encoder, disables the analog output enables and clears the soft-start bit. Register and table contents are kept through the reset. A hardware-start mode bit then selects one of two start-ups. In the first, line 1 of field 1 begins as soon as reset is released. In the second, the encoder waits for software to set the soft-start bit.

Top module: `regclut_port`

## Requirements
- R1: Function code `addr` selects the target: 0 is the register pointer, 1 is register data, 2 is the table index and 3 is table data. A write to 0 or 2 loads that pointer. A read of 0 or 2 returns the pointer's current value.
- R2: Each register data read or write accesses the register under the pointer and then adds one to the pointer. The pointer wraps modulo 16, so 15 is followed by 0.
- R3: Table data writes take bytes in the order red, green, blue. The third write commits {red[23:16], green[15:8], blue[7:0]} to the entry at the index and then adds one to the index, which wraps from 255 to 0. Loading the index restarts the order at red.
- R4: Table data reads return the red, green and blue bytes of the entry under the index, in that order. The index advances after the blue byte.
- R5: `lut_rgb` shows the table entry addressed by `lut_idx` one clock after `lut_idx` is applied.
- R6: `rdata` changes only on a read access. It shows that access's byte after the clock edge of the access and holds it until the next read.
- R7: While `rst_n` is low, `run` is 0, `pdown` is 1, both output enables are 0 and `rdata` is 0. Reset clears both pointers, the table byte order and the soft-start bit (register 0 bit 0). All other register bits and all table entries keep their values.
- R8: When register 0 bit 1 (hardware-start mode) is 1, `start` pulses and `run` rises in the first clock after `rst_n` is released. While that bit is 1, writes to the soft-start bit neither stop nor restart the encoder.
- R9: When register 0 bit 1 is 0, the encoder stays idle after reset. Writing register 0 with bit 0 set gives a `start` pulse and `run` one clock after the write edge. Writing bit 0 clear while running drops `run` one clock after the write edge.
- R10: Register 14 bit 7 enables the extended power controls. Only when it is 1 does bit 6 clear `comp_en` and bit 5 clear `yc_en`. While running with bit 7 at 0, both enables are 1.
- R11: `start` is high for exactly one clock per start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| sel | input | 1 | Host access strobe, one access per clock it is high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Function code (pointer or data, register or table) |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte, registered |
| lut_idx | input | 8 | Pipeline lookup index into the colour table |
| lut_rgb | output | 24 | Registered table entry {R,G,B} for `lut_idx` |
| run | output | 1 | Encoder running (line timing active) |
| start | output | 1 | One-clock pulse when line 1 of field 1 begins |
| pdown | output | 1 | Power-down indication, inverse of `run` |
| comp_en | output | 1 | Composite output enable |
| yc_en | output | 1 | Luma/chroma output enable |

## Verification
A read byte is due on `rdata` right after the clock edge of its access, and a lookup entry is due on `lut_rgb` one edge after `lut_idx` is applied. The bench drives every input at a falling edge and samples at the falling edge that follows the edge concerned. A soft-start write acts one edge after its own write edge, and the hardware-start pulse appears at the first edge after reset release. For these, the bench waits that extra falling edge before it looks at `start` and `run`, then checks on the next falling edge that the pulse has ended. The output enables follow the register contents without any added register, so the bench checks them at the falling edge right after the write.

// File: rtl/regclut_pkg.sv
package regclut_pkg;

    localparam int BYTE_W = 8;
    localparam int NUM_FN = 4;

    typedef enum logic [1:0] {
        FN_REG_PTR = 2'd0,
        FN_REG_DAT = 2'd1,
        FN_TAB_PTR = 2'd2,
        FN_TAB_DAT = 2'd3
    } fn_e;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        ST_HELD = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2
    } start_e;

endpackage

// File: rtl/hp_decode.sv
module hp_decode
    import regclut_pkg::*;
(
    input  logic              sel,
    input  logic              rd_wr,
    input  logic [1:0]        addr,
    output logic [NUM_FN-1:0] wr_o,
    output logic [NUM_FN-1:0] rd_o
);

    logic [NUM_FN-1:0] hit;

    for (genvar i = 0; i < NUM_FN; i++) begin : g_hit
        assign hit[i] = sel && (addr == 2'(i));
    end

    assign wr_o = hit & {NUM_FN{~rd_wr}};
    assign rd_o = hit & {NUM_FN{rd_wr}};

endmodule

// File: rtl/hp_regfile.sv
module hp_regfile
    import regclut_pkg::*;
#(
    parameter int REG_AW   = 4,
    parameter int CTRL_IDX = 0,
    parameter int PWR_IDX  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic [REG_AW-1:0] ptr_o,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              sreset_o,
    output logic              hreset_o,
    output logic              ext_en_o,
    output logic              comp_pd_o,
    output logic              yc_pd_o
);

    localparam int NREG = 1 << REG_AW;

    typedef struct packed {
        logic [REG_AW-1:0] ptr;
        logic              sreset;
    } rf_state_t;

    rf_state_t   s_d, s_q;
    logic [BYTE_W-1:0] regs_q [NREG];
    logic        at_ctrl;

    assign at_ctrl = (s_q.ptr == REG_AW'(CTRL_IDX));

    always_comb begin
        s_d = s_q;
        if (ptr_wr) begin
            s_d.ptr = REG_AW'(wdata);
        end else if (dat_wr || dat_rd) begin
            s_d.ptr = s_q.ptr + 1'b1;
        end
        if (dat_wr && at_ctrl) begin
            s_d.sreset = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // contents survive the reset pin
    always_ff @(posedge clk) begin
        if (dat_wr) begin
            regs_q[s_q.ptr] <= wdata;
        end
    end

    assign rd_byte   = at_ctrl ? {regs_q[s_q.ptr][BYTE_W-1:1], s_q.sreset}
                               : regs_q[s_q.ptr];
    assign ptr_o     = s_q.ptr;
    assign sreset_o  = s_q.sreset;
    assign hreset_o  = regs_q[CTRL_IDX][1];
    assign ext_en_o  = regs_q[PWR_IDX][7];
    assign comp_pd_o = regs_q[PWR_IDX][6];
    assign yc_pd_o   = regs_q[PWR_IDX][5];

endmodule

// File: rtl/hp_clut.sv
module hp_clut
    import regclut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ptr_wr,
    input  logic                dat_wr,
    input  logic                dat_rd,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic [IDX_W-1:0]    lut_idx,
    output logic [IDX_W-1:0]    idx_o,
    output logic [BYTE_W-1:0]   rd_byte,
    output logic [3*BYTE_W-1:0] lut_rgb_o
);

    localparam int NENT  = 1 << IDX_W;
    localparam int ENT_W = 3 * BYTE_W;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        phase_e            ph;
        logic [BYTE_W-1:0] red;
        logic [BYTE_W-1:0] green;
        logic [ENT_W-1:0]  lut;
    } ct_state_t;

    ct_state_t        s_d, s_q;
    logic [ENT_W-1:0] mem_q [NENT];
    logic [ENT_W-1:0] cur_ent;
    logic             commit;

    assign cur_ent = mem_q[s_q.idx];
    assign commit  = dat_wr && (s_q.ph == PH_BLUE);

    always_comb begin
        s_d     = s_q;
        s_d.lut = mem_q[lut_idx];
        if (ptr_wr) begin
            s_d.idx = IDX_W'(wdata);
            s_d.ph  = PH_RED;
        end else if (dat_wr || dat_rd) begin
            unique case (s_q.ph)
                PH_RED: begin
                    if (dat_wr) s_d.red = wdata;
                    s_d.ph = PH_GREEN;
                end
                PH_GREEN: begin
                    if (dat_wr) s_d.green = wdata;
                    s_d.ph = PH_BLUE;
                end
                default: begin
                    s_d.ph  = PH_RED;
                    s_d.idx = s_q.idx + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{idx: '0, ph: PH_RED, red: '0, green: '0, lut: '0};
        end else begin
            s_q <= s_d;
        end
    end

    // table contents survive the reset pin
    always_ff @(posedge clk) begin
        if (commit) begin
            mem_q[s_q.idx] <= {s_q.red, s_q.green, wdata};
        end
    end

    always_comb begin
        unique case (s_q.ph)
            PH_RED:   rd_byte = cur_ent[3*BYTE_W-1:2*BYTE_W];
            PH_GREEN: rd_byte = cur_ent[2*BYTE_W-1:BYTE_W];
            default:  rd_byte = cur_ent[BYTE_W-1:0];
        endcase
    end

    assign idx_o     = s_q.idx;
    assign lut_rgb_o = s_q.lut;

endmodule

// File: rtl/hp_startctl.sv
module hp_startctl
    import regclut_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hreset,
    input  logic sreset,
    output logic run_o,
    output logic start_o
);

    typedef struct packed {
        start_e st;
        logic   start;
    } sc_state_t;

    sc_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        unique case (s_q.st)
            ST_HELD: begin
                if (hreset) begin
                    s_d.st    = ST_RUN;
                    s_d.start = 1'b1;
                end else begin
                    s_d.st = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (!hreset && sreset) begin
                    s_d.st    = ST_RUN;
                    s_d.start = 1'b1;
                end
            end
            default: begin
                if (!hreset && !sreset) begin
                    s_d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_HELD, start: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o   = (s_q.st == ST_RUN);
    assign start_o = s_q.start;

endmodule

// File: rtl/regclut_port.sv
module regclut_port
    import regclut_pkg::*;
#(
    parameter int REG_AW   = 4,
    parameter int IDX_W    = 8,
    parameter int CTRL_IDX = 0,
    parameter int PWR_IDX  = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                rd_wr,
    input  logic [1:0]          addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    input  logic [IDX_W-1:0]    lut_idx,
    output logic [23:0]         lut_rgb,
    output logic                run,
    output logic                start,
    output logic                pdown,
    output logic                comp_en,
    output logic                yc_en
);

    logic [NUM_FN-1:0] fn_wr, fn_rd;
    logic [REG_AW-1:0] reg_ptr;
    logic [IDX_W-1:0]  tab_idx;
    logic [7:0]        reg_byte, tab_byte;
    logic              sreset_w, hreset_w, ext_en_w, comp_pd_w, yc_pd_w;
    logic [7:0]        rdata_d, rdata_q;

    hp_decode u_dec (
        .sel   (sel),
        .rd_wr (rd_wr),
        .addr  (addr),
        .wr_o  (fn_wr),
        .rd_o  (fn_rd)
    );

    hp_regfile #(
        .REG_AW   (REG_AW),
        .CTRL_IDX (CTRL_IDX),
        .PWR_IDX  (PWR_IDX)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_wr    (fn_wr[FN_REG_PTR]),
        .dat_wr    (fn_wr[FN_REG_DAT]),
        .dat_rd    (fn_rd[FN_REG_DAT]),
        .wdata     (wdata),
        .ptr_o     (reg_ptr),
        .rd_byte   (reg_byte),
        .sreset_o  (sreset_w),
        .hreset_o  (hreset_w),
        .ext_en_o  (ext_en_w),
        .comp_pd_o (comp_pd_w),
        .yc_pd_o   (yc_pd_w)
    );

    hp_clut #(
        .IDX_W (IDX_W)
    ) u_ct (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_wr    (fn_wr[FN_TAB_PTR]),
        .dat_wr    (fn_wr[FN_TAB_DAT]),
        .dat_rd    (fn_rd[FN_TAB_DAT]),
        .wdata     (wdata),
        .lut_idx   (lut_idx),
        .idx_o     (tab_idx),
        .rd_byte   (tab_byte),
        .lut_rgb_o (lut_rgb)
    );

    hp_startctl u_sc (
        .clk     (clk),
        .rst_n   (rst_n),
        .hreset  (hreset_w),
        .sreset  (sreset_w),
        .run_o   (run),
        .start_o (start)
    );

    always_comb begin
        rdata_d = rdata_q;
        unique case (1'b1)
            fn_rd[FN_REG_PTR]: rdata_d = 8'(reg_ptr);
            fn_rd[FN_REG_DAT]: rdata_d = reg_byte;
            fn_rd[FN_TAB_PTR]: rdata_d = 8'(tab_idx);
            fn_rd[FN_TAB_DAT]: rdata_d = tab_byte;
            default:           rdata_d = rdata_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata   = rdata_q;
    assign pdown   = ~run;
    assign comp_en = run & ~(ext_en_w & comp_pd_w);
    assign yc_en   = run & ~(ext_en_w & yc_pd_w);

endmodule

// File: rtl/hp_checker.sv
module hp_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic run,
    input logic comp_en,
    input logic yc_en,
    input logic ext_en,
    input logic hreset
);

    p_start_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    p_start_with_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> run);

    p_run_begins_with_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> start);

    p_outputs_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!comp_en && !yc_en));

    p_legacy_enables_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ext_en) |-> (comp_en && yc_en));

    p_hw_mode_keeps_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hreset) |=> run);

endmodule

bind regclut_port hp_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .run     (run),
    .comp_en (comp_en),
    .yc_en   (yc_en),
    .ext_en  (ext_en_w),
    .hreset  (hreset_w)
);

// File: tb/regclut_port_test.sv
module regclut_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        rd_wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic [7:0]  lut_idx = 8'd0;
    logic [23:0] lut_rgb;
    logic        run, start, pdown, comp_en, yc_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  mreg [16];
    logic        msres;
    logic [3:0]  mptr;
    logic [23:0] mtab [256];
    bit          mval [256];
    logic [7:0]  midx;

    regclut_port uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_wr(rd_wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb),
        .run(run), .start(start), .pdown(pdown), .comp_en(comp_en), .yc_en(yc_en)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_exp(input logic [3:0] p);
        return (p == 4'd0) ? {mreg[0][7:1], msres} : mreg[p];
    endfunction

    task automatic acc(input logic [1:0] a, input logic rw, input logic [7:0] wd,
                       output logic [7:0] rd);
        @(negedge clk);
        sel = 1'b1; addr = a; rd_wr = rw; wdata = wd;
        @(negedge clk);
        sel = 1'b0;
        rd = rdata;
    endtask

    task automatic reg_ptr(input logic [7:0] p);
        logic [7:0] d;
        acc(2'd0, 1'b0, p, d);
        mptr = p[3:0];
    endtask

    task automatic reg_wr(input logic [7:0] v);
        logic [7:0] d;
        acc(2'd1, 1'b0, v, d);
        mreg[mptr] = v;
        if (mptr == 4'd0) msres = v[0];
        mptr = mptr + 1'b1;
    endtask

    task automatic reg_rd_chk(input string req);
        logic [7:0] d;
        logic [7:0] e;
        e = reg_exp(mptr);
        acc(2'd1, 1'b1, 8'd0, d);
        check(req, {24'd0, d}, {24'd0, e});
        mptr = mptr + 1'b1;
    endtask

    task automatic tab_ptr(input logic [7:0] i);
        logic [7:0] d;
        acc(2'd2, 1'b0, i, d);
        midx = i;
    endtask

    task automatic tab_wr(input logic [23:0] v);
        logic [7:0] d;
        acc(2'd3, 1'b0, v[23:16], d);
        acc(2'd3, 1'b0, v[15:8], d);
        acc(2'd3, 1'b0, v[7:0], d);
        mtab[midx] = v;
        mval[midx] = 1'b1;
        midx = midx + 1'b1;
    endtask

    task automatic tab_rd_chk(input string req);
        logic [7:0] r, g, b;
        acc(2'd3, 1'b1, 8'd0, r);
        acc(2'd3, 1'b1, 8'd0, g);
        acc(2'd3, 1'b1, 8'd0, b);
        check(req, {8'd0, r, g, b}, {8'd0, mtab[midx]});
        midx = midx + 1'b1;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        msres = 1'b0; mptr = 4'd0; midx = 8'd0;
        #1;
        check("R7 run in reset", {31'd0, run}, 32'd0);
        check("R7 pdown in reset", {31'd0, pdown}, 32'd1);
        check("R7 enables in reset", {30'd0, comp_en, yc_en}, 32'd0);
        check("R7 rdata in reset", {24'd0, rdata}, 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] v;
        logic [23:0] e;
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) mreg[i] = 8'd0;
        for (int i = 0; i < 256; i++) mval[i] = 1'b0;
        msres = 1'b0; mptr = 4'd0; midx = 8'd0;

        // R7 reset state, then a known control register
        repeat (2) @(negedge clk);
        #1;
        check("R7 run in reset", {31'd0, run}, 32'd0);
        check("R7 enables in reset", {30'd0, comp_en, yc_en}, 32'd0);
        rst_n = 1'b1;
        reg_ptr(8'd0);
        reg_wr(8'h00);
        reg_ptr(8'd14);
        reg_wr(8'h00);
        pulse_reset();
        repeat (3) @(negedge clk);
        check("R9 idle after reset", {31'd0, run}, 32'd0);
        check("R9 no start when idle", {31'd0, start}, 32'd0);

        // R9 soft start and stop
        reg_ptr(8'd0);
        reg_wr(8'h01);
        check("R9 start not yet", {31'd0, start}, 32'd0);
        @(negedge clk);
        check("R9 start pulse", {31'd0, start}, 32'd1);
        check("R9 run after soft start", {31'd0, run}, 32'd1);
        @(negedge clk);
        check("R11 start ends", {31'd0, start}, 32'd0);
        reg_ptr(8'd0);
        reg_wr(8'h00);
        check("R9 run before stop edge", {31'd0, run}, 32'd1);
        @(negedge clk);
        check("R9 run after soft stop", {31'd0, run}, 32'd0);
        reg_ptr(8'd0);
        reg_wr(8'h01);
        repeat (2) @(negedge clk);
        check("R9 restart", {31'd0, run}, 32'd1);

        // R10 power controls
        reg_ptr(8'd14);
        reg_wr(8'h60);
        check("R10 legacy ignores bits", {30'd0, comp_en, yc_en}, 32'd3);
        reg_ptr(8'd14);
        reg_wr(8'hC0);
        check("R10 composite off", {30'd0, comp_en, yc_en}, 32'd1);
        reg_ptr(8'd14);
        reg_wr(8'hA0);
        check("R10 luma chroma off", {30'd0, comp_en, yc_en}, 32'd2);
        reg_ptr(8'd14);
        reg_wr(8'h80);
        check("R10 both on", {30'd0, comp_en, yc_en}, 32'd3);

        // R1 pointer readback, R2 wrap
        reg_ptr(8'd15);
        acc(2'd0, 1'b1, 8'd0, d);
        check("R1 reg pointer read", {24'd0, d}, 32'd15);
        reg_wr(8'h3C);
        reg_wr(8'h5D);
        acc(2'd0, 1'b1, 8'd0, d);
        check("R2 pointer wraps", {24'd0, d}, 32'd1);
        reg_ptr(8'd15);
        reg_rd_chk("R2 read reg15");
        reg_rd_chk("R2 read reg0 after wrap");

        // R6 rdata held across writes
        acc(2'd0, 1'b1, 8'd0, d);
        v = d;
        reg_ptr(8'd3);
        reg_wr(8'hAA);
        check("R6 rdata held", {24'd0, rdata}, {24'd0, v});

        // R2 random register bursts
        for (int k = 0; k < 40; k++) begin
            v = 8'($urandom_range(0, 15));
            reg_ptr(v);
            n = $urandom_range(1, 20);
            for (int j = 0; j < n; j++) begin
                d = 8'($urandom);
                if (mptr == 4'd0) d = (d & 8'hFC) | 8'h01;
                reg_wr(d);
            end
            reg_ptr(v);
            for (int j = 0; j < n; j++) reg_rd_chk("R2 burst readback");
        end

        // R3/R4 table bursts
        for (int k = 0; k < 20; k++) begin
            v = 8'($urandom);
            tab_ptr(v);
            n = $urandom_range(1, 6);
            for (int j = 0; j < n; j++) tab_wr(24'($urandom));
            tab_ptr(v);
            acc(2'd2, 1'b1, 8'd0, d);
            check("R1 table index read", {24'd0, d}, {24'd0, v});
            for (int j = 0; j < n; j++) tab_rd_chk("R4 table readback");
        end

        // R3 index wrap 255 -> 0
        tab_ptr(8'd255);
        tab_wr(24'h112233);
        tab_wr(24'h445566);
        acc(2'd2, 1'b1, 8'd0, d);
        check("R3 index wraps", {24'd0, d}, 32'd1);
        tab_ptr(8'd255);
        tab_rd_chk("R3 entry 255");
        tab_rd_chk("R3 entry 0 after wrap");

        // R3 index load restarts byte order
        tab_ptr(8'd7);
        acc(2'd3, 1'b0, 8'hEE, d);
        tab_ptr(8'd7);
        tab_wr(24'hA1B2C3);
        tab_ptr(8'd7);
        tab_rd_chk("R3 order restarts");

        // R5 lookup port
        for (int k = 0; k < 256; k++) begin
            if (mval[k] && ($urandom_range(0, 3) == 0 || k == 7)) begin
                @(negedge clk);
                lut_idx = 8'(k);
                @(negedge clk);
                check("R5 lookup", {8'd0, lut_rgb}, {8'd0, mtab[k]});
            end
        end

        // R7 contents kept through reset
        pulse_reset();
        @(negedge clk);
        check("R7 idle with hw mode off", {31'd0, run}, 32'd0);
        acc(2'd0, 1'b1, 8'd0, d);
        check("R7 reg pointer cleared", {24'd0, d}, 32'd0);
        acc(2'd2, 1'b1, 8'd0, d);
        check("R7 table index cleared", {24'd0, d}, 32'd0);
        for (int j = 0; j < 16; j++) reg_rd_chk("R7 register kept");
        tab_ptr(8'd255);
        tab_rd_chk("R7 table entry kept");
        pulse_reset();
        tab_wr(24'h0F1E2D);
        tab_ptr(8'd0);
        tab_rd_chk("R7 byte order reset");

        // R8 hardware start mode
        reg_ptr(8'd0);
        reg_wr(8'h02);
        pulse_reset();
        @(negedge clk);
        check("R8 start on release", {31'd0, start}, 32'd1);
        check("R8 run on release", {31'd0, run}, 32'd1);
        @(negedge clk);
        check("R11 start ends hw", {31'd0, start}, 32'd0);
        reg_ptr(8'd0);
        reg_wr(8'h02);
        @(negedge clk);
        check("R8 soft clear ignored", {31'd0, run}, 32'd1);
        reg_ptr(8'd0);
        reg_wr(8'h03);
        @(negedge clk);
        check("R8 soft set no pulse", {31'd0, start}, 32'd0);
        check("R8 still running", {31'd0, run}, 32'd1);

        e = 24'd0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule